// File: doc/BRIEF.md
# Six-Channel Serial Potentiometer Updater

This block keeps six wiper settings for a chain of serially programmed digital potentiometers. It writes all of them out over a three-wire link made of a listen-enable line, a bit clock and a data line. A request can step one channel up or down by one position. Stepping saturates at both ends, and an out-of-range stored value is forced back into range. Any accepted step request, or a plain update strobe, starts a broadcast that rewrites every channel in a fixed order.

Each channel goes out as an 8-bit frame. The two top bits are always ones, because the device treats them as load bits, and the low six bits carry the channel's setting. Bits are sent least significant first. Every bit has a setup phase with the clock low and then a clock-high phase. A gap with the link released separates consecutive frames. The length of each phase is set in system clock cycles by a run-time input. A request that arrives during a broadcast does not start a second broadcast at once. It is folded into a single pending rerun, while the stored setting changes at once.

Top module: `serpot_updater`

## Requirements
- R1: After reset every setting is 0, `pot_sel` is 0, `pot_clk` and `pot_dat` are 1 and `busy` is 0, and nothing is sent until a request arrives.
- R2: A broadcast sends exactly six frames, for channel index 0, 1, 2, 3, 4, 5 in that order.
- R3: A frame is `{1'b1, 1'b1, setting[5:0]}`. It is shifted out LSB first, with one bit taken on each rising edge of `pot_clk` while `pot_sel` is 1, and exactly 8 rising edges per frame.
- R4: `pot_sel` is 1 for the whole of a frame and drops to 0 after the eighth bit's clock-high phase. Whenever `pot_sel` is 0, `pot_clk` and `pot_dat` are both 1.
- R5: With P = max(`phase_cycles`, 1), every clock-low setup phase lasts P cycles and every clock-high phase lasts P cycles. Between frames `pot_sel` is 0 for P cycles. `pot_dat` does not change while `pot_clk` is high.
- R6: A step-up (`step_up`=1) on a value below 64 adds 1, and on a value of 64 or more sets 63. Stored values never exceed 64.
- R7: A step-down (`step_up`=0) leaves 0 at 0, subtracts 1 from a value in 1..64, and sets 0 for a value of 65 or more.
- R8: A step request changes only the channel selected by `step_ch` and starts a broadcast. The frame sent for that channel already carries the new value, even when the request arrives in the cycle the broadcast starts.
- R9: Any number of requests during a broadcast add exactly one more full broadcast after it. Steps made during a broadcast change the settings at once, and the rerun carries them.
- R10: `busy` is 1 from the cycle after an accepted request until the last gap of the last broadcast has finished. It is 0 otherwise.
- R11: A step request with `step_ch` of 6 or 7 changes no setting and starts no broadcast.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| step_valid | input | 1 | One-cycle step request |
| step_ch | input | 3 | Channel index of the step request (0..5 valid) |
| step_up | input | 1 | Step direction: 1 up, 0 down |
| update | input | 1 | One-cycle request to rewrite all channels |
| phase_cycles | input | 8 | Cycles per setup, clock-high and gap phase (0 treated as 1) |
| pot_sel | output | 1 | Listen enable to the potentiometer chain, 1 while a frame is sent |
| pot_clk | output | 1 | Bit clock, data taken on its rising edge |
| pot_dat | output | 1 | Serial data, LSB first |
| busy | output | 1 | Broadcast running or pending |

## Verification
Channel 0 is swept upward by 66 steps and downward by 66 steps from reset. This passes through the 63-to-64 step, the forced return from 64 to 63 and the floor at 0. Each broadcast is decoded from the link and compared with an arithmetic model, which separates a wrong limit from an off-by-one frame or a stale first frame. The other channels get distinct small values, so a channel-order or cross-channel write error shows up as a mismatched frame. Phase lengths of 1, 3 and 0 check the setup, high and gap timing. Bursts of requests during a broadcast must yield exactly twelve frames, and invalid channel indices must yield none.

// File: rtl/serpot_pkg.sv
package serpot_pkg;

    typedef enum logic [1:0] {
        LS_IDLE  = 2'd0,
        LS_SETUP = 2'd1,
        LS_HIGH  = 2'd2,
        LS_GAP   = 2'd3
    } link_st_e;

endpackage

// File: rtl/sp_step_calc.sv
// Saturating step of one channel value; forces out-of-range values back in.
module sp_step_calc #(
    parameter int PW = 6
) (
    input  logic [PW:0] cur,
    input  logic        up,
    output logic [PW:0] nxt
);
    localparam logic [PW:0] CEIL = {1'b1, {PW{1'b0}}};

    always_comb begin
        if (up) begin
            nxt = (cur < CEIL) ? cur + 1'b1 : CEIL - 1'b1;
        end else if (cur == '0) begin
            nxt = '0;
        end else if (cur <= CEIL) begin
            nxt = cur - 1'b1;
        end else begin
            nxt = '0;
        end
    end
endmodule

// File: rtl/sp_link_seq.sv
// Serializes one frame per channel over the three-wire link and handles reruns.
module sp_link_seq
    import serpot_pkg::*;
#(
    parameter int NCH       = 6,
    parameter int PAYLOAD_W = 6,
    parameter int FRAME_W   = 8,
    parameter int DIV_W     = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     kick,
    input  logic [NCH*PAYLOAD_W-1:0] pay_flat,
    input  logic [DIV_W-1:0]         phase_cycles,
    output logic                     pot_sel,
    output logic                     pot_clk,
    output logic                     pot_dat,
    output logic                     busy
);
    localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int BIT_W = $clog2(FRAME_W);
    localparam int LOAD_W = FRAME_W - PAYLOAD_W;
    localparam logic [CH_W-1:0]  CH_LAST  = CH_W'(NCH - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_W - 1);

    typedef struct packed {
        link_st_e           st;
        logic [CH_W-1:0]    ch;
        logic [BIT_W-1:0]   bitn;
        logic [DIV_W-1:0]   cnt;
        logic [FRAME_W-1:0] frame;
        logic               pending;
    } seq_t;

    seq_t q, d;

    logic [DIV_W-1:0]     reload;
    logic [CH_W-1:0]      nxt_ch;
    logic [PAYLOAD_W-1:0] pay_sel;
    logic [FRAME_W-1:0]   frame_next;

    assign reload     = (phase_cycles == '0) ? '0 : phase_cycles - 1'b1;
    assign nxt_ch     = (q.ch == CH_LAST) ? '0 : q.ch + 1'b1;
    assign pay_sel    = pay_flat[int'(nxt_ch) * PAYLOAD_W +: PAYLOAD_W];
    assign frame_next = {{LOAD_W{1'b1}}, pay_sel};

    always_comb begin
        d = q;
        if (q.st != LS_IDLE && kick) begin
            d.pending = 1'b1;
        end
        case (q.st)
            LS_IDLE: begin
                if (kick) begin
                    d.st    = LS_SETUP;
                    d.ch    = nxt_ch;
                    d.bitn  = '0;
                    d.cnt   = reload;
                    d.frame = frame_next;
                end
            end
            LS_SETUP: begin
                if (q.cnt == '0) begin
                    d.st  = LS_HIGH;
                    d.cnt = reload;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            LS_HIGH: begin
                if (q.cnt == '0) begin
                    d.cnt = reload;
                    if (q.bitn == BIT_LAST) begin
                        d.st = LS_GAP;
                    end else begin
                        d.st   = LS_SETUP;
                        d.bitn = q.bitn + 1'b1;
                    end
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            LS_GAP: begin
                if (q.cnt != '0) begin
                    d.cnt = q.cnt - 1'b1;
                end else if (q.ch != CH_LAST || q.pending || kick) begin
                    if (q.ch == CH_LAST) begin
                        d.pending = 1'b0;
                    end
                    d.st    = LS_SETUP;
                    d.ch    = nxt_ch;
                    d.bitn  = '0;
                    d.cnt   = reload;
                    d.frame = frame_next;
                end else begin
                    d.st = LS_IDLE;
                end
            end
            default: d.st = LS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st      <= LS_IDLE;
            q.ch      <= CH_LAST;
            q.bitn    <= '0;
            q.cnt     <= '0;
            q.frame   <= '1;
            q.pending <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign pot_sel = (q.st == LS_SETUP) || (q.st == LS_HIGH);
    assign pot_clk = (q.st != LS_SETUP);
    assign pot_dat = pot_sel ? q.frame[q.bitn] : 1'b1;
    assign busy    = (q.st != LS_IDLE);
endmodule

// File: rtl/serpot_updater.sv
// Holds the channel settings, applies step requests and drives the link sequencer.
module serpot_updater
    import serpot_pkg::*;
#(
    parameter int NCH       = 6,
    parameter int PAYLOAD_W = 6,
    parameter int FRAME_W   = 8,
    parameter int DIV_W     = 8,
    parameter int CH_W      = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step_valid,
    input  logic [CH_W-1:0] step_ch,
    input  logic            step_up,
    input  logic            update,
    input  logic [DIV_W-1:0] phase_cycles,
    output logic            pot_sel,
    output logic            pot_clk,
    output logic            pot_dat,
    output logic            busy
);
    localparam int VW = PAYLOAD_W + 1;

    typedef struct packed {
        logic [NCH-1:0][VW-1:0] val;
    } set_t;

    set_t st_q, st_d;

    logic [NCH-1:0][VW-1:0]     stepped;
    logic [NCH*PAYLOAD_W-1:0]   pay_flat;
    logic [NCH*VW-1:0]          cur_flat;
    logic                       ch_ok;
    logic                       kick;

    assign ch_ok    = ({1'b0, step_ch} < (CH_W + 1)'(NCH));
    assign kick     = update || (step_valid && ch_ok);
    assign cur_flat = st_q.val;

    for (genvar gi = 0; gi < NCH; gi++) begin : g_ch
        sp_step_calc #(.PW(PAYLOAD_W)) u_calc (
            .cur (st_q.val[gi]),
            .up  (step_up),
            .nxt (stepped[gi])
        );
        assign pay_flat[gi*PAYLOAD_W +: PAYLOAD_W] = st_d.val[gi][PAYLOAD_W-1:0];
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NCH; i++) begin
            if (step_valid && ch_ok && step_ch == CH_W'(i)) begin
                st_d.val[i] = stepped[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    sp_link_seq #(
        .NCH       (NCH),
        .PAYLOAD_W (PAYLOAD_W),
        .FRAME_W   (FRAME_W),
        .DIV_W     (DIV_W)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .kick         (kick),
        .pay_flat     (pay_flat),
        .phase_cycles (phase_cycles),
        .pot_sel      (pot_sel),
        .pot_clk      (pot_clk),
        .pot_dat      (pot_dat),
        .busy         (busy)
    );
endmodule

// File: rtl/serpot_checker.sv
module serpot_checker #(
    parameter int NCH       = 6,
    parameter int PAYLOAD_W = 6,
    parameter int FRAME_W   = 8,
    parameter int CH_W      = 3
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        step_valid,
    input logic [CH_W-1:0]             step_ch,
    input logic                        step_up,
    input logic                        update,
    input logic                        pot_sel,
    input logic                        pot_clk,
    input logic                        pot_dat,
    input logic                        busy,
    input logic [NCH*(PAYLOAD_W+1)-1:0] set_flat
);
    localparam int VW = PAYLOAD_W + 1;
    localparam logic [VW-1:0] CEIL = {1'b1, {PAYLOAD_W{1'b0}}};

    logic            ch_ok;
    logic            kick;
    logic [CH_W-1:0] ch_idx;
    logic [CH_W-1:0] ch_idx_q;
    logic [VW-1:0]   sel_val;
    logic [VW-1:0]   now_val;
    logic            clk_prev;
    logic [7:0]      rise_cnt;

    assign ch_ok   = ({1'b0, step_ch} < (CH_W + 1)'(NCH));
    assign kick    = update || (step_valid && ch_ok);
    assign ch_idx  = ch_ok ? step_ch : '0;
    assign sel_val = set_flat[int'(ch_idx) * VW +: VW];
    assign now_val = set_flat[int'(ch_idx_q) * VW +: VW];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch_idx_q <= '0;
            clk_prev <= 1'b1;
            rise_cnt <= '0;
        end else begin
            ch_idx_q <= ch_idx;
            clk_prev <= pot_clk;
            if (!pot_sel) begin
                rise_cnt <= '0;
            end else if (pot_clk && !clk_prev) begin
                rise_cnt <= rise_cnt + 1'b1;
            end
        end
    end

    // R10: a broadcast only starts in response to an accepted request
    a_r10_start_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(kick));

    // R4: link released whenever the listen line is idle
    a_r4_released_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !pot_sel |-> (pot_clk && pot_dat));

    // R5: data holds while the clock is high
    a_r5_data_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
        (pot_sel && pot_clk && $past(pot_sel && pot_clk)) |-> $stable(pot_dat));

    // R3: eight clock pulses per frame
    a_r3_eight_pulses: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pot_sel) |-> (rise_cnt == 8'(FRAME_W)));

    // R7: stepping down at zero stays at zero
    a_r7_floor_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (step_valid && ch_ok && !step_up && sel_val == '0) |=> (now_val == '0));

    // R6: a step up on a value at the ceiling falls back below it
    a_r6_ceiling_back: assert property (@(posedge clk) disable iff (!rst_n)
        (step_valid && ch_ok && step_up && sel_val == CEIL) |=> (now_val == CEIL - 1'b1));

    for (genvar gi = 0; gi < NCH; gi++) begin : g_rng
        // R6: stored values never exceed the ceiling
        a_r6_in_range: assert property (@(posedge clk) disable iff (!rst_n)
            set_flat[gi*VW +: VW] <= CEIL);
    end
endmodule

bind serpot_updater serpot_checker #(
    .NCH       (NCH),
    .PAYLOAD_W (PAYLOAD_W),
    .FRAME_W   (FRAME_W),
    .CH_W      (CH_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_valid (step_valid),
    .step_ch    (step_ch),
    .step_up    (step_up),
    .update     (update),
    .pot_sel    (pot_sel),
    .pot_clk    (pot_clk),
    .pot_dat    (pot_dat),
    .busy       (busy),
    .set_flat   (cur_flat)
);

// File: tb/sim_serpot_updater.sv
`timescale 1ns/1ps
module sim_serpot_updater;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       step_valid = 1'b0;
    logic [2:0] step_ch = '0;
    logic       step_up = 1'b0;
    logic       update = 1'b0;
    logic [7:0] phase_cycles = 8'd1;
    logic       pot_sel, pot_clk, pot_dat, busy;

    int tests = 0;
    int fails = 0;
    int model [6];
    int exp_p = 1;

    logic [7:0] frames [0:4095];
    int         fbits  [0:4095];
    int         nfr = 0;
    logic [7:0] m_sh = '0;
    int         m_nb = 0;
    logic       m_pclk = 1'b1;
    logic       m_psel = 1'b0;
    int         lo_run = 0, hi_run = 0, gap_run = 0, last_gap = 0;
    int         tim_err = 0, idle_err = 0;

    always #2.5 clk = ~clk;

    serpot_updater u0 (
        .clk (clk), .rst_n (rst_n), .step_valid (step_valid), .step_ch (step_ch),
        .step_up (step_up), .update (update), .phase_cycles (phase_cycles),
        .pot_sel (pot_sel), .pot_clk (pot_clk), .pot_dat (pot_dat), .busy (busy)
    );

    // Link monitor: decodes frames and measures phase lengths
    always @(negedge clk) begin
        if (rst_n) begin
            if (pot_sel && pot_clk && !m_pclk) begin
                m_sh = {pot_dat, m_sh[7:1]};
                m_nb++;
            end
            if (pot_sel && !pot_clk) lo_run++;
            else if (lo_run != 0) begin
                if (lo_run != exp_p) tim_err++;
                lo_run = 0;
            end
            if (pot_sel && pot_clk) hi_run++;
            else if (hi_run != 0) begin
                if (hi_run != exp_p) tim_err++;
                hi_run = 0;
            end
            if (!pot_sel) begin
                gap_run++;
                if (!(pot_clk && pot_dat)) idle_err++;
            end else begin
                if (!m_psel) last_gap = gap_run;
                gap_run = 0;
            end
            if (!pot_sel && m_psel) begin
                frames[nfr % 4096] = m_sh;
                fbits[nfr % 4096]  = m_nb;
                nfr++;
                m_nb = 0;
            end
            m_pclk = pot_clk;
            m_psel = pot_sel;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int step_model(input int v, input bit up);
        if (up) return (v < 64) ? v + 1 : 63;
        if (v == 0) return 0;
        if (v <= 64) return v - 1;
        return 0;
    endfunction

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    task automatic pulse_update();
        @(negedge clk);
        update = 1'b1;
        @(negedge clk);
        update = 1'b0;
    endtask

    task automatic do_step(input int ch, input bit up);
        @(negedge clk);
        step_valid = 1'b1;
        step_ch = 3'(ch);
        step_up = up;
        if (ch < 6) model[ch] = step_model(model[ch], up);
        @(negedge clk);
        step_valid = 1'b0;
    endtask

    task automatic verify(input int base, input int nexp, input string req);
        check(nfr - base == nexp, "R2 frame count", nfr - base, nexp);
        for (int i = 0; i < 6; i++) begin
            int idx = (nfr - 6 + i) % 4096;
            int expf = 192 + (model[i] % 64);
            check(frames[idx] == 8'(expf), req, int'(frames[idx]), expf);
            check(fbits[idx] == 8, "R3 bits per frame", fbits[idx], 8);
        end
    endtask

    initial begin
        int base;
        for (int i = 0; i < 6; i++) model[i] = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        // R1 reset state and silence
        check(pot_sel == 1'b0, "R1 sel idle", int'(pot_sel), 0);
        check(pot_clk == 1'b1 && pot_dat == 1'b1, "R1 lines released", int'({pot_clk, pot_dat}), 3);
        check(busy == 1'b0, "R1 busy", int'(busy), 0);
        check(nfr == 0, "R1 no frames", nfr, 0);

        // R2 / R10 plain update
        base = nfr;
        pulse_update();
        check(busy == 1'b1, "R10 busy after request", int'(busy), 1);
        wait_idle();
        verify(base, 6, "R2 all-zero frames");

        // R6 / R7 / R8 sweep channel 0
        for (int k = 0; k < 66; k++) begin
            base = nfr;
            do_step(0, 1'b1);
            check(busy == 1'b1, "R8 step starts broadcast", int'(busy), 1);
            wait_idle();
            verify(base, 6, "R6 step up");
        end
        for (int k = 0; k < 66; k++) begin
            base = nfr;
            do_step(0, 1'b0);
            wait_idle();
            verify(base, 6, "R7 step down");
        end
        // R8 distinct values on the other channels
        for (int ch = 1; ch < 6; ch++) begin
            for (int k = 0; k <= ch; k++) begin
                base = nfr;
                do_step(ch, 1'b1);
                wait_idle();
                verify(base, 6, "R8 single channel");
            end
        end
        base = nfr;
        do_step(3, 1'b0);
        wait_idle();
        verify(base, 6, "R8 step down other");
        check(tim_err == 0, "R5 phase length P=1", tim_err, 0);
        check(last_gap == 1, "R5 gap P=1", last_gap, 1);
        check(idle_err == 0, "R4 released while idle", idle_err, 0);

        // R5 timing with longer phases and with zero
        phase_cycles = 8'd3;
        exp_p = 3;
        base = nfr;
        pulse_update();
        wait_idle();
        verify(base, 6, "R5 frames P=3");
        check(tim_err == 0, "R5 phase length P=3", tim_err, 0);
        check(last_gap == 3, "R5 gap P=3", last_gap, 3);
        phase_cycles = 8'd0;
        exp_p = 1;
        base = nfr;
        pulse_update();
        wait_idle();
        verify(base, 6, "R5 frames P=0");
        check(tim_err == 0, "R5 phase length P=0", tim_err, 0);
        check(last_gap == 1, "R5 gap P=0", last_gap, 1);
        phase_cycles = 8'd1;

        // R11 invalid channel
        base = nfr;
        do_step(6, 1'b1);
        do_step(7, 1'b0);
        repeat (40) @(negedge clk);
        check(busy == 1'b0, "R11 no broadcast", int'(busy), 0);
        check(nfr == base, "R11 no frames", nfr - base, 0);
        pulse_update();
        wait_idle();
        verify(base, 6, "R11 settings unchanged");

        // R9 requests during a broadcast collapse into one rerun
        base = nfr;
        pulse_update();
        repeat (5) @(negedge clk);
        do_step(2, 1'b1);
        do_step(4, 1'b0);
        pulse_update();
        wait_idle();
        verify(base, 12, "R9 rerun carries new values");
        check(tim_err == 0, "R5 timing overall", tim_err, 0);
        check(idle_err == 0, "R4 released overall", idle_err, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL R10 watchdog actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule